// File: doc/BRIEF.md
# Dual vectored interrupt priority encoder

This block looks at the raw request lines of two 32-source interrupt controllers and, every cycle, names the one request that software should serve next. Each controller owns a small table of programmable priority slots. Each slot holds an enable and a 6-bit interrupt number. A request that an enabled slot claims is a vectored request. Every other active request line is served by a plain scan of its controller's status word.

The winner is reported as an 11-bit registered code. Bit 8 marks a vectored winner, and the low six bits then carry the slot's interrupt number. Bit 9 marks an unvectored winner on controller 1 and bit 10 marks one on controller 2. An all-zero code means nothing is pending. Software reads this code on entry to its interrupt handler. It can branch on the class bits or use the vectored number directly, with no search through the status words.

Slots are programmed through a simple write strobe that selects a controller and a slot index. Resolution is global across both controllers. The order is controller 1 slots, then controller 2 slots, then unvectored controller 1 requests, then unvectored controller 2 requests.

Top module: `irq_vec_encoder`

## Requirements
- R1: After reset the code is 0x000 and every slot of both tables is disabled, so any active request gives an unvectored code.
- R2: An enabled slot on a controller is active when that controller's status bit selected by the slot number's low five bits is set. A winning vectored slot gives code 0x100 OR its full 6-bit number. For example, slot number 0x18 on controller 2 with status bit 24 set gives 0x118, and number 0 gives 0x100.
- R3: Within one table, when several enabled slots are active, the lowest slot index wins.
- R4: Global order: vectored slots of controller 1, then vectored slots of controller 2, then unvectored controller 1, then unvectored controller 2.
- R5: An unvectored winner on controller 1 gives exactly 0x200, and one on controller 2 gives exactly 0x400. The low eight bits are zero in both cases.
- R6: With no status bit set on either controller, the code is 0x000.
- R7: A disabled slot has no effect, even when its status bit is set.
- R8: The code is registered. It reflects status sampled at the previous rising edge, and a slot write takes effect on the code one cycle after the edge that performs it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_stat1 | input | 32 | Raw request lines of controller 1 (interrupt numbers 0 to 31) |
| irq_stat2 | input | 32 | Raw request lines of controller 2 (interrupt numbers 32 to 63) |
| cfg_we | input | 1 | Slot write strobe |
| cfg_ctl | input | 1 | Controller select for the write (0 = controller 1, 1 = controller 2) |
| cfg_slot | input | 2 | Slot index for the write |
| cfg_en | input | 1 | Enable value written to the slot |
| cfg_irq | input | 6 | Interrupt number written to the slot |
| vec_code | output | 11 | Registered winner code |

## Verification
The bench aims at the case where IRQ 0 is vectored. A design that left out bit 8 would return 0x000 and hide the request. It sets a vectored request on controller 2 at the same time as an unvectored request on controller 1. An encoder that ranked the controllers ahead of the class would wrongly return 0x200. It also tests a disabled slot whose line is active, a controller 2 line whose index matches a controller 1 slot, and two active slots in one table. Each of these reveals a design that decodes the wrong slot or the wrong controller. Latency checks sample the code just before and just after the edge, which catches a missing or an extra register stage.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;
  localparam int NSRC  = 32;
  localparam int NSLOT = 4;
  localparam int IRQW  = 6;
  localparam int CODEW = 11;
  localparam int SELW  = $clog2(NSRC);
  localparam int SLTW  = $clog2(NSLOT);

  localparam logic [CODEW-1:0] CODE_NONE = '0;
  localparam logic [CODEW-1:0] CODE_VEC  = CODEW'(1) << 8;
  localparam logic [CODEW-1:0] CODE_DEF1 = CODEW'(1) << 9;
  localparam logic [CODEW-1:0] CODE_DEF2 = CODEW'(1) << 10;

  function automatic logic [CODEW-1:0] vec_code_of(input logic [IRQW-1:0] num);
    return CODE_VEC | CODEW'(num);
  endfunction

  function automatic logic [CODEW-1:0] resolve(
    input logic            hit1,
    input logic [IRQW-1:0] num1,
    input logic            hit2,
    input logic [IRQW-1:0] num2,
    input logic            any1,
    input logic            any2);
    if (hit1)      return vec_code_of(num1);
    else if (hit2) return vec_code_of(num2);
    else if (any1) return CODE_DEF1;
    else if (any2) return CODE_DEF2;
    else           return CODE_NONE;
  endfunction
endpackage

// File: rtl/irq_slot_table.sv
module irq_slot_table
  import irq_vec_pkg::*;
(
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr,
  input  logic [SLTW-1:0]            wr_slot,
  input  logic                       wr_en,
  input  logic [IRQW-1:0]            wr_num,
  output logic [NSLOT-1:0]           slot_en,
  output logic [NSLOT-1:0][IRQW-1:0] slot_num
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slot_en  <= '0;
      slot_num <= '0;
    end else if (wr) begin
      slot_en[wr_slot]  <= wr_en;
      slot_num[wr_slot] <= wr_num;
    end
  end
endmodule

// File: rtl/irq_slot_pick.sv
module irq_slot_pick
  import irq_vec_pkg::*;
(
  input  logic [NSRC-1:0]            stat,
  input  logic [NSLOT-1:0]           slot_en,
  input  logic [NSLOT-1:0][IRQW-1:0] slot_num,
  output logic                       hit,
  output logic [IRQW-1:0]            num
);
  always_comb begin
    hit = 1'b0;
    num = '0;
    for (int i = NSLOT - 1; i >= 0; i--) begin
      if (slot_en[i] && stat[slot_num[i][SELW-1:0]]) begin
        hit = 1'b1;
        num = slot_num[i];
      end
    end
  end
endmodule

// File: rtl/irq_vec_encoder.sv
module irq_vec_encoder
  import irq_vec_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NSRC-1:0]       irq_stat1,
  input  logic [NSRC-1:0]       irq_stat2,
  input  logic                  cfg_we,
  input  logic                  cfg_ctl,
  input  logic [SLTW-1:0]       cfg_slot,
  input  logic                  cfg_en,
  input  logic [IRQW-1:0]       cfg_irq,
  output logic [CODEW-1:0]      vec_code
);
  logic [1:0][NSRC-1:0]  stat;
  logic [1:0]            vhit;
  logic [1:0][IRQW-1:0]  vnum;
  logic                  vec1_hit;
  logic                  vec2_hit;
  logic                  any1;
  logic                  any2;

  assign stat[0] = irq_stat1;
  assign stat[1] = irq_stat2;

  for (genvar c = 0; c < 2; c++) begin : g_ctl
    logic [NSLOT-1:0]           en;
    logic [NSLOT-1:0][IRQW-1:0] nums;

    irq_slot_table u_tab (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr       (cfg_we && (cfg_ctl == 1'(c))),
      .wr_slot  (cfg_slot),
      .wr_en    (cfg_en),
      .wr_num   (cfg_irq),
      .slot_en  (en),
      .slot_num (nums)
    );

    irq_slot_pick u_pick (
      .stat     (stat[c]),
      .slot_en  (en),
      .slot_num (nums),
      .hit      (vhit[c]),
      .num      (vnum[c])
    );
  end

  assign vec1_hit = vhit[0];
  assign vec2_hit = vhit[1];
  assign any1     = |irq_stat1;
  assign any2     = |irq_stat2;

  always_ff @(posedge clk) begin
    if (!rst_n) vec_code <= CODE_NONE;
    else        vec_code <= resolve(vec1_hit, vnum[0], vec2_hit, vnum[1], any1, any2);
  end
endmodule

// File: rtl/irq_vec_encoder_chk.sv
module irq_vec_encoder_chk
  import irq_vec_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic [NSRC-1:0]  stat1,
  input logic [NSRC-1:0]  stat2,
  input logic             hit1,
  input logic             hit2,
  input logic [CODEW-1:0] code
);
  // R5: class bits are mutually exclusive
  a_r5_one_class: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(code[10:8]));

  // R5: unvectored codes carry zero low bits
  a_r5_unvec_low_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (code[9] || code[10]) |-> (code[7:0] == 8'h00));

  // R6: nothing pending gives the idle code
  a_r6_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (stat1 == '0 && stat2 == '0) |=> (code == CODE_NONE));

  // R4: any vectored hit wins the class
  a_r4_vec_first: assert property (@(posedge clk) disable iff (!rst_n)
    (hit1 || hit2) |=> code[8]);

  // R4: unvectored controller 1 beats unvectored controller 2
  a_r4_def1: assert property (@(posedge clk) disable iff (!rst_n)
    (!hit1 && !hit2 && stat1 != '0) |=> (code == CODE_DEF1));
endmodule

bind irq_vec_encoder irq_vec_encoder_chk u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .stat1 (irq_stat1),
  .stat2 (irq_stat2),
  .hit1  (vec1_hit),
  .hit2  (vec2_hit),
  .code  (vec_code)
);

// File: tb/irq_vec_encoder_test.sv
module irq_vec_encoder_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] irq_stat1 = '0;
  logic [31:0] irq_stat2 = '0;
  logic        cfg_we = 1'b0;
  logic        cfg_ctl = 1'b0;
  logic [1:0]  cfg_slot = '0;
  logic        cfg_en = 1'b0;
  logic [5:0]  cfg_irq = '0;
  logic [10:0] vec_code;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  irq_vec_encoder uut (
    .clk(clk), .rst_n(rst_n), .irq_stat1(irq_stat1), .irq_stat2(irq_stat2),
    .cfg_we(cfg_we), .cfg_ctl(cfg_ctl), .cfg_slot(cfg_slot), .cfg_en(cfg_en),
    .cfg_irq(cfg_irq), .vec_code(vec_code)
  );

  // {stat1, stat2, expected code}
  localparam int NV = 16;
  localparam logic [74:0] VEC [NV] = '{
    {32'h0000_0000, 32'h0000_0000, 11'h000},  // R6
    {32'h0000_0008, 32'h0000_0000, 11'h103},  // R2
    {32'h0000_0001, 32'h0000_0000, 11'h100},  // R2 IRQ 0
    {32'h0000_0009, 32'h0000_0000, 11'h103},  // R3
    {32'h0000_0000, 32'h0100_0000, 11'h118},  // R2 example
    {32'h0000_0000, 32'h0000_0020, 11'h105},  // R2
    {32'h0000_0000, 32'h0100_0020, 11'h118},  // R3
    {32'h0000_0200, 32'h0100_0000, 11'h118},  // R4
    {32'h0000_0200, 32'h0000_0000, 11'h200},  // R5
    {32'h0000_0000, 32'h0000_0200, 11'h400},  // R5
    {32'h0000_0200, 32'h0000_0200, 11'h200},  // R4
    {32'h0000_0080, 32'h0000_0000, 11'h200},  // R7
    {32'h0000_0008, 32'h0100_0000, 11'h103},  // R4
    {32'h0000_0000, 32'h0000_0008, 11'h400},  // R2 wrong controller
    {32'h0000_0000, 32'h8000_0000, 11'h13F},  // R2 full number
    {32'h0000_0000, 32'h0000_0000, 11'h000}   // R6
  };

  task automatic check(input string req, input logic [10:0] exp);
    n_chk++;
    if (vec_code !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, vec_code, exp);
    end
  endtask

  task automatic wr_slot(input logic c, input logic [1:0] s, input logic e, input logic [5:0] n);
    @(negedge clk);
    cfg_we = 1'b1; cfg_ctl = c; cfg_slot = s; cfg_en = e; cfg_irq = n;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic apply(input logic [31:0] s1, input logic [31:0] s2);
    @(negedge clk);
    irq_stat1 = s1; irq_stat2 = s2;
    @(posedge clk); #1;
  endtask

  initial begin
    #400000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 check("R1 reset code", 11'h000);
    @(negedge clk); rst_n = 1'b1;
    apply(32'h0000_0008, 32'h0);
    check("R1 slots disabled after reset", 11'h200);
    apply(32'h0, 32'h0);

    wr_slot(1'b0, 2'd0, 1'b1, 6'd3);
    wr_slot(1'b0, 2'd1, 1'b1, 6'd0);
    wr_slot(1'b0, 2'd3, 1'b0, 6'd7);
    wr_slot(1'b1, 2'd0, 1'b1, 6'h18);
    wr_slot(1'b1, 2'd1, 1'b1, 6'd5);
    wr_slot(1'b1, 2'd2, 1'b1, 6'h3F);

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][74:43], VEC[i][42:11]);
      check($sformatf("R2/R3/R4/R5/R6/R7 vector %0d", i), VEC[i][10:0]);
    end

    // R8: status change appears only after the next edge
    @(negedge clk);
    irq_stat1 = 32'h0000_0008;
    #1 check("R8 before edge", 11'h000);
    @(posedge clk); #1;
    check("R8 after edge", 11'h103);

    // R8/R7: disabling a slot takes effect one cycle after the write edge
    @(negedge clk);
    cfg_we = 1'b1; cfg_ctl = 1'b0; cfg_slot = 2'd0; cfg_en = 1'b0; cfg_irq = 6'd3;
    @(posedge clk); #1;
    check("R8 write edge keeps old code", 11'h103);
    @(negedge clk); cfg_we = 1'b0;
    @(posedge clk); #1;
    check("R7 disabled slot ignored", 11'h200);

    // R1: mid-run reset clears the tables
    @(negedge clk); rst_n = 1'b0; irq_stat2 = 32'h0100_0000;
    @(posedge clk); #1;
    check("R1 reset clears code", 11'h000);
    @(negedge clk); rst_n = 1'b1; irq_stat1 = 32'h0;
    @(posedge clk); #1;
    check("R1 slots cleared by reset", 11'h400);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule